// File: doc/BRIEF.md
# Programmable Pseudorandom and Repeating Pattern Transmitter

This block is the sending half of a bit error-rate tester. It has two sources. One is a linear feedback shift register whose length (1 to 32 stages) and feedback tap set can both be changed at run time. The other is a small pattern memory, filled by software, that is replayed as a repeating byte sequence of programmable length. Each clock, the chosen source delivers 1, 4 or 8 bits. Software can ask for a single inverted bit to be placed in the outgoing stream, so that the receiving checker can be tested.

A single write-only register port sets up the block. The eight register addresses are: 0 control (bits [1:0] output width code, bit 2 source select with 1 for the pattern memory, bit 3 run), 1 register length, 2 tap mask, 3 state load, 4 pattern length in bytes, 5 memory write pointer, 6 memory write data, 7 error request. The transmit path has no link to any receive logic. It runs whenever the run bit is set.

Top module: `prbs_tx_gen`

## Requirements
- R1: After reset, tx_valid and tx_data are 0. The defaults are: shift register state 1, length 7, tap mask 0x60, pattern length 0, write pointer 0 and control 0.
- R2: In register mode, each step emits state bit n-1. It then shifts the state left by one, places the XOR of the state bits selected by the tap mask (restricted to the low n bits) into bit 0, and keeps only the low n bits. A length of 0 acts as 1 and a length above 32 acts as 32.
- R3: The width code is taken from control bits [1:0]: 0 gives 1 bit per clock, 1 gives 4 and 2 or 3 gives 8. Each clock the source advances by that many steps. The bits are right-aligned in tx_data with the earliest bit in the highest valid position, and all bits above the field are 0.
- R4: When the low n bits of the state are all zero at the start of a clock, the state is taken as 1 for that clock's generation, so the generator never locks up.
- R5: A write to address 3 loads the state with the written value masked to n bits. The next word is generated from that state.
- R6: In memory mode, bytes are sent from byte 0 upward, each starting with its bit 7. After byte L-1 the sequence returns to byte 0, where L is the pattern length. A length of 0 or one above the memory depth acts as the full depth.
- R7: A write to address 5 sets the memory write pointer. A write to address 6 stores data bits [7:0] at the pointer and then increments the pointer, which returns to 0 after the last byte.
- R8: Every write to address 0 restarts the memory sequence at byte 0, bit 7. It does not disturb the shift register state.
- R9: A write to address 7 inverts bit 0 of the next word sent while running, and of no other word. The request is held while the block is stopped.
- R10: While the run bit is 0, tx_valid and tx_data are 0 and both sources hold their position. A later run continues the register sequence where it stopped.
- R11: Output is registered. The first word appears one clock after the edge that stores the run bit, and each later clock carries the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 32 | Register write data |
| tx_data | output | 8 | Output word, right-aligned field |
| tx_valid | output | 1 | Output word is valid |

## Verification
The bench builds the block with a pattern memory of 16 bytes. With that depth, a length value of 0 and the full-depth wrap of both the read sequence and the write pointer can be reached within a few dozen clocks. The shift register keeps its fixed 32-bit span, so the bench covers lengths 0, 1, 4, 7, 32 and 40. It also covers zero and out-of-range states, and all three output widths with both sources.

// File: rtl/prbs_tx_pkg.sv
package prbs_tx_pkg;

  localparam int SR_W   = 32;
  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    WM_SERIAL = 2'd0,
    WM_NIBBLE = 2'd1,
    WM_BYTE   = 2'd2
  } wmode_e;

  typedef struct packed {
    logic [SR_W-1:0]   st;
    logic [WORD_W-1:0] bits;
  } sr_res_t;

  // steps per clock for each width
  function automatic logic [3:0] steps_of(input wmode_e m);
    case (m)
      WM_SERIAL: return 4'd1;
      WM_NIBBLE: return 4'd4;
      default:   return 4'd8;
    endcase
  endfunction

  // programmed length clamped to 1..32
  function automatic logic [5:0] len_eff(input logic [5:0] n);
    if (n == 6'd0) return 6'd1;
    if (n > 6'd32) return 6'd32;
    return n;
  endfunction

  function automatic logic [SR_W-1:0] len_mask(input logic [5:0] n);
    logic [5:0] e;
    e = len_eff(n);
    if (e == 6'd32) return '1;
    return (SR_W'(1) << e) - SR_W'(1);
  endfunction

  // advance the register k steps, earliest bit ends up highest
  function automatic sr_res_t sr_run(input logic [SR_W-1:0] st,
                                     input logic [SR_W-1:0] taps,
                                     input logic [SR_W-1:0] mask,
                                     input logic [4:0]      msb,
                                     input logic [3:0]      k);
    sr_res_t r;
    logic fb;
    r.st   = st;
    r.bits = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (i < int'(k)) begin
        r.bits = {r.bits[WORD_W-2:0], r.st[msb]};
        fb     = ^(r.st & taps & mask);
        r.st   = ((r.st << 1) | SR_W'(fb)) & mask;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/prbs_cfg_regs.sv
module prbs_cfg_regs
  import prbs_tx_pkg::*;
#(
  parameter int PAT_BYTES = 512,
  parameter int PTR_W     = 9,
  parameter int PLEN_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output wmode_e            wmode,
  output logic              src_ram,
  output logic              run,
  output logic [5:0]        len_n,
  output logic [SR_W-1:0]   taps,
  output logic              seed_we,
  output logic [SR_W-1:0]   seed_val,
  output logic [PLEN_W-1:0] plen,
  output logic              ram_we,
  output logic [PTR_W-1:0]  ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              restart,
  output logic              inj_req
);

  localparam logic [2:0] A_CTRL = 3'd0, A_LEN = 3'd1, A_TAPS = 3'd2, A_SEED = 3'd3,
                         A_PLEN = 3'd4, A_WPTR = 3'd5, A_WDAT = 3'd6, A_INJ = 3'd7;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(PAT_BYTES - 1);

  logic [PTR_W-1:0] wptr_q;

  assign seed_we   = cfg_we && cfg_addr == A_SEED;
  assign seed_val  = cfg_wdata;
  assign restart   = cfg_we && cfg_addr == A_CTRL;
  assign inj_req   = cfg_we && cfg_addr == A_INJ;
  assign ram_we    = cfg_we && cfg_addr == A_WDAT;
  assign ram_waddr = wptr_q;
  assign ram_wdata = cfg_wdata[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wmode   <= WM_SERIAL;
      src_ram <= 1'b0;
      run     <= 1'b0;
      len_n   <= 6'd7;
      taps    <= SR_W'(32'h60);
      plen    <= '0;
      wptr_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        A_CTRL: begin
          case (cfg_wdata[1:0])
            2'd0:    wmode <= WM_SERIAL;
            2'd1:    wmode <= WM_NIBBLE;
            default: wmode <= WM_BYTE;
          endcase
          src_ram <= cfg_wdata[2];
          run     <= cfg_wdata[3];
        end
        A_LEN:  len_n  <= cfg_wdata[5:0];
        A_TAPS: taps   <= cfg_wdata;
        A_PLEN: plen   <= cfg_wdata[PLEN_W-1:0];
        A_WPTR: wptr_q <= cfg_wdata[PTR_W-1:0];
        A_WDAT: wptr_q <= (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
        default: ;
      endcase
    end
  end

  // R7: pointer moves on by one after each data write
  assert_wptr_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> wptr_q == (($past(wptr_q) == PTR_LAST) ? '0 : $past(wptr_q) + 1'b1));

endmodule

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core
  import prbs_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [3:0]        nsteps,
  input  logic [5:0]        len_n,
  input  logic [SR_W-1:0]   taps,
  input  logic              seed_we,
  input  logic [SR_W-1:0]   seed_val,
  output logic [WORD_W-1:0] bits,
  output logic              zero_fix
);

  logic [SR_W-1:0] state_q;
  logic [SR_W-1:0] mask;
  logic [SR_W-1:0] eff_state;
  logic [4:0]      msb;
  sr_res_t         res;

  assign mask      = len_mask(len_n);
  assign msb       = 5'(len_eff(len_n) - 6'd1);
  assign zero_fix  = (state_q & mask) == '0;
  assign eff_state = zero_fix ? SR_W'(1) : (state_q & mask);
  assign res       = sr_run(eff_state, taps, mask, msb, nsteps);
  assign bits      = res.bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SR_W'(1);
    else if (seed_we) state_q <= seed_val & mask;
    else if (adv)     state_q <= res.st;
  end

  // R5: a load lands in the state, masked to the length
  assert_seed_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> state_q == ($past(seed_val) & $past(mask)));

  // R10: the state holds while not advancing
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !seed_we) |=> $stable(state_q));

endmodule

// File: rtl/prbs_pattern_seq.sv
module prbs_pattern_seq
  import prbs_tx_pkg::*;
#(
  parameter int PAT_BYTES = 512,
  parameter int PTR_W     = 9,
  parameter int PLEN_W    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              restart,
  input  wmode_e            wmode,
  input  logic [PLEN_W-1:0] plen,
  input  logic              ram_we,
  input  logic [PTR_W-1:0]  ram_waddr,
  input  logic [7:0]        ram_wdata,
  output logic [WORD_W-1:0] bits
);

  logic [7:0]        mem_q [PAT_BYTES];
  logic [PTR_W-1:0]  ptr_q;
  logic [2:0]        phase_q;
  logic [2:0]        phase_nx;
  logic [7:0]        cur;
  logic              byte_done;
  logic              at_last;
  logic [PLEN_W-1:0] plen_eff;

  always_ff @(posedge clk) begin
    if (ram_we) mem_q[ram_waddr] <= ram_wdata;
  end

  assign plen_eff = (plen == '0 || plen > PLEN_W'(PAT_BYTES)) ? PLEN_W'(PAT_BYTES) : plen;
  assign at_last  = PLEN_W'(ptr_q) >= plen_eff - 1'b1;
  assign cur      = mem_q[ptr_q];

  always_comb begin
    case (wmode)
      WM_SERIAL: begin
        bits      = {7'b0, cur[3'd7 - phase_q]};
        byte_done = phase_q == 3'd7;
        phase_nx  = phase_q + 3'd1;
      end
      WM_NIBBLE: begin
        bits      = {4'b0, phase_q[2] ? cur[3:0] : cur[7:4]};
        byte_done = phase_q[2];
        phase_nx  = phase_q + 3'd4;
      end
      default: begin
        bits      = cur;
        byte_done = 1'b1;
        phase_nx  = 3'd0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      phase_q <= '0;
    end else if (restart) begin
      ptr_q   <= '0;
      phase_q <= '0;
    end else if (adv) begin
      phase_q <= phase_nx;
      if (byte_done) ptr_q <= at_last ? '0 : ptr_q + 1'b1;
    end
  end

  // R6: the read position returns to byte 0 after the last byte
  assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && byte_done && at_last && !restart) |=> ptr_q == '0);

  // R8: a control write puts the sequence back at its start
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ptr_q == '0 && phase_q == '0));

endmodule

// File: rtl/prbs_err_out.sv
module prbs_err_out
  import prbs_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              inj_req,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              pend_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
    end else begin
      tx_valid <= run;
      tx_data  <= run ? (word ^ WORD_W'(pend_q)) : '0;
      if (inj_req)          pend_q <= 1'b1;
      else if (run && pend_q) pend_q <= 1'b0;
    end
  end

  // R9: one flipped bit, then the request is gone
  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pend_q && !inj_req) |=> !pend_q);

  assert_err_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pend_q) |=> tx_data[0] != $past(word[0]));

  // R10: a stopped block sends nothing
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> tx_data == '0);

endmodule

// File: rtl/prbs_tx_gen.sv
module prbs_tx_gen
  import prbs_tx_pkg::*;
#(
  parameter int PAT_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid
);

  localparam int PTR_W  = $clog2(PAT_BYTES);
  localparam int PLEN_W = $clog2(PAT_BYTES + 1);

  wmode_e            wmode;
  logic              src_ram, run, seed_we, ram_we, restart, inj_req;
  logic [5:0]        len_n;
  logic [SR_W-1:0]   taps, seed_val;
  logic [PLEN_W-1:0] plen;
  logic [PTR_W-1:0]  ram_waddr;
  logic [7:0]        ram_wdata;
  logic [WORD_W-1:0] sr_bits, pat_bits, word;
  logic              zero_fix, pend_q;
  logic              adv_sr, adv_pat;

  assign adv_sr  = run && !src_ram;
  assign adv_pat = run && src_ram;
  assign word    = src_ram ? pat_bits : sr_bits;

  prbs_cfg_regs #(.PAT_BYTES(PAT_BYTES), .PTR_W(PTR_W), .PLEN_W(PLEN_W)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .wmode, .src_ram, .run, .len_n, .taps, .seed_we, .seed_val, .plen,
    .ram_we, .ram_waddr, .ram_wdata, .restart, .inj_req
  );

  prbs_lfsr_core u_sr (
    .clk, .rst_n, .adv(adv_sr), .nsteps(steps_of(wmode)), .len_n, .taps,
    .seed_we, .seed_val, .bits(sr_bits), .zero_fix
  );

  prbs_pattern_seq #(.PAT_BYTES(PAT_BYTES), .PTR_W(PTR_W), .PLEN_W(PLEN_W)) u_pat (
    .clk, .rst_n, .adv(adv_pat), .restart, .wmode, .plen,
    .ram_we, .ram_waddr, .ram_wdata, .bits(pat_bits)
  );

  prbs_err_out u_out (
    .clk, .rst_n, .run, .inj_req, .word, .tx_data, .tx_valid, .pend_q
  );

  // R3: a serial word uses bit 0 only
  assert_serial_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && wmode == WM_SERIAL && $past(wmode) == WM_SERIAL) |-> tx_data[7:1] == '0);

  // R4: a zero state never reaches the output as a dead run in serial width
  assert_zero_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_sr && zero_fix && !pend_q && wmode == WM_SERIAL && len_eff(len_n) > 6'd1)
      |=> tx_data == '0);

endmodule

// File: tb/prbs_tx_gen_tb.sv
module prbs_tx_gen_tb;

  localparam int DEPTH = 16;

  typedef struct {
    logic [7:0] d;
    string      tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  tx_data;
  logic        tx_valid;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  // bench model state
  logic [31:0] mst;
  logic [31:0] mtaps;
  int          mn;
  logic [7:0]  mmem [DEPTH];

  always #5 clk = ~clk;

  prbs_tx_gen #(.PAT_BYTES(DEPTH)) u_dut (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .tx_data, .tx_valid
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_valid && exp_q.size() > 0) begin
      exp_t it;
      it = exp_q.pop_front();
      check(it.tag, tx_data, it.d);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int clamp_n(input int n);
    if (n == 0) return 1;
    if (n > 32) return 32;
    return n;
  endfunction

  function automatic logic [31:0] keep_low(input logic [31:0] v, input int n);
    logic [31:0] r;
    r = '0;
    for (int j = 0; j < n; j++) r[j] = v[j];
    return r;
  endfunction

  // one clock worth of k register steps, per R2/R3/R4
  function automatic logic [7:0] mdl_word(input int k);
    logic [7:0] w;
    logic fb;
    w = '0;
    if (keep_low(mst, mn) == '0) mst = 32'd1;
    for (int s = 0; s < k; s++) begin
      w = {w[6:0], mst[mn-1]};
      fb = 1'b0;
      for (int j = 0; j < mn; j++) fb = fb ^ (mst[j] & mtaps[j]);
      mst = keep_low({mst[30:0], fb}, mn);
    end
    return w;
  endfunction

  function automatic int width_of(input int code);
    if (code == 0) return 1;
    if (code == 1) return 4;
    return 8;
  endfunction

  task automatic setup_sr(input int n, input logic [31:0] t, input logic [31:0] seed);
    wr(3'd1, 32'(n));
    wr(3'd2, t);
    wr(3'd3, seed);
    mn = clamp_n(n); mtaps = t; mst = keep_low(seed, mn);
  endtask

  task automatic push_sr(input int code, input int cnt, input string tag, input bit flip_first);
    for (int i = 0; i < cnt; i++) begin
      exp_t it;
      it.d = mdl_word(width_of(code));
      if (flip_first && i == 0) it.d[0] = ~it.d[0];
      it.tag = tag;
      exp_q.push_back(it);
    end
  endtask

  task automatic push_pat(input int code, input int plen, input int cnt, input string tag);
    int p, ph, L;
    p = 0; ph = 0;
    L = (plen == 0 || plen > DEPTH) ? DEPTH : plen;
    for (int i = 0; i < cnt; i++) begin
      exp_t it;
      it.tag = tag;
      if (code == 0) begin
        it.d = {7'b0, mmem[p][7-ph]}; ph++;
        if (ph == 8) begin ph = 0; p = (p + 1) % L; end
      end else if (code == 1) begin
        it.d = (ph == 0) ? {4'b0, mmem[p][7:4]} : {4'b0, mmem[p][3:0]};
        ph = (ph == 0) ? 4 : 0;
        if (ph == 0) p = (p + 1) % L;
      end else begin
        it.d = mmem[p]; p = (p + 1) % L;
      end
      exp_q.push_back(it);
    end
  endtask

  task automatic stop(input bit sr_mode, input int code, input string tag);
    wait (exp_q.size() == 0);
    wr(3'd0, 32'(code));
    // two extra words leave the register before the stop lands (R11 timing)
    if (sr_mode) begin
      logic [7:0] dummy;
      dummy = mdl_word(width_of(code));
      dummy = mdl_word(width_of(code));
    end
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(tag, {7'b0, tx_valid}, 8'h00);
      check(tag, tx_data, 8'h00);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    check("R1 tx_data", tx_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 default configuration, R2 serial, R11 first word timing
    mn = 7; mtaps = 32'h60; mst = 32'd1;
    push_sr(0, 20, "R1 R2 R11 default serial", 1'b0);
    wr(3'd0, 32'h8);
    stop(1'b1, 0, "R10 idle");

    // R3 nibble steps with a 4-stage register
    setup_sr(4, 32'hC, 32'h9);
    push_sr(1, 10, "R3 nibble", 1'b0);
    wr(3'd0, 32'h9);
    stop(1'b1, 1, "R10 idle");

    // R3 byte with full 32 stages, R5 load
    setup_sr(32, 32'h8020_0003, 32'hDEAD_BEEF);
    push_sr(2, 8, "R3 R5 byte n32", 1'b0);
    wr(3'd0, 32'hA);
    stop(1'b1, 2, "R10 idle");

    // R10 resume continues the register sequence; width code 3 acts as byte
    push_sr(3, 6, "R10 resume", 1'b0);
    wr(3'd0, 32'hB);
    stop(1'b1, 3, "R10 idle");

    // R2 length 0 acts as 1
    setup_sr(0, 32'h1, 32'h1);
    push_sr(0, 8, "R2 len0", 1'b0);
    wr(3'd0, 32'h8);
    stop(1'b1, 0, "R10 idle");

    // R2 length above 32 acts as 32
    setup_sr(40, 32'h8020_0003, 32'h1234_5678);
    push_sr(2, 6, "R2 len40", 1'b0);
    wr(3'd0, 32'hA);
    stop(1'b1, 2, "R10 idle");

    // R4 zero state, then state with only out-of-range bits set
    setup_sr(4, 32'hC, 32'h0);
    push_sr(1, 6, "R4 zero seed", 1'b0);
    wr(3'd0, 32'h9);
    stop(1'b1, 1, "R10 idle");
    setup_sr(4, 32'hC, 32'hF0);
    push_sr(1, 6, "R4 masked zero", 1'b0);
    wr(3'd0, 32'h9);
    stop(1'b1, 1, "R10 idle");

    // R9 request held while stopped, flips bit 0 of first word only
    setup_sr(7, 32'h60, 32'h55);
    wr(3'd7, 32'h0);
    repeat (3) @(negedge clk);
    push_sr(2, 5, "R9 inject", 1'b1);
    wr(3'd0, 32'hA);
    stop(1'b1, 2, "R10 idle");

    // R7 load the pattern memory through the write pointer, wrapping once
    wr(3'd5, 32'd3);
    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] v;
      v = 8'((i + 3) * 37 + 11);
      mmem[(i + 3) % DEPTH] = v;
      wr(3'd6, {24'b0, v});
    end

    // R6 R7 byte mode, length 3
    wr(3'd4, 32'd3);
    push_pat(2, 3, 7, "R6 R7 byte len3");
    wr(3'd0, 32'hE);
    stop(1'b0, 2, "R10 idle");

    // R8 a second run starts again at byte 0
    push_pat(2, 3, 3, "R8 restart");
    wr(3'd0, 32'hE);
    stop(1'b0, 2, "R10 idle");

    // R6 nibble, length 2
    wr(3'd4, 32'd2);
    push_pat(1, 2, 6, "R6 nibble len2");
    wr(3'd0, 32'hD);
    stop(1'b0, 1, "R10 idle");

    // R6 serial, length 1
    wr(3'd4, 32'd1);
    push_pat(0, 1, 16, "R6 serial len1");
    wr(3'd0, 32'hC);
    stop(1'b0, 0, "R10 idle");

    // R6 length 0 gives full depth
    wr(3'd4, 32'd0);
    push_pat(2, 0, 20, "R6 len0 full");
    wr(3'd0, 32'hE);
    stop(1'b0, 2, "R10 idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule